// File: doc/BRIEF.md
# Multi-Source Set-Reset Latch Peripheral

This peripheral holds one bit of state that several independent event sources can drive high or low. Four hardware sources feed it: two comparator results, an external pin, and a one-cycle clock strobe. Each source has a separate enable for the set side and for the reset side. Firmware can also set or clear the bit by writing self-clearing request bits. Each firmware request becomes a set or reset pulse of fixed width. Both set and reset are active-high. When both are asserted in the same cycle, reset wins.

The stored bit reaches two pin outputs, one true and one inverted. Each pin has its own output enable, and both are qualified by a global latch enable. A disabled pin drives 0. The comparator and pin inputs are asynchronous, so each passes through a two-flop synchronizer before gating. The stored bit is a flop on the system clock with no reset. A device reset therefore leaves it unchanged, and firmware must place it in a known state before enabling the pins.

Top module: `srl_latch_periph`

## Requirements
- R1: When an input is enabled on the set side (enable register, address 0, bits 0..3 for comparator 1, comparator 2, pin, strobe) and that input is high, the stored bit becomes 1. An asynchronous input is seen on the true pin 3 clock edges after it changes.
- R2: When an input is enabled on the reset side (address 0, bits 4..7, same source order) and that input is high, the stored bit becomes 0.
- R3: When any active set and any active reset occur in the same cycle, the stored bit becomes 0.
- R4: A source whose enable bit is 0 has no effect on the stored bit.
- R5: A one-cycle strobe pulse with its enable set acts as exactly one set or reset event, taking effect on the edge that samples it.
- R6: Writing 1 to control bit 3 (address 1) sets the stored bit, and writing 1 to control bit 4 clears it. The effect is visible one edge after the write edge. Both bits read back as 0.
- R7: A firmware request produces a set or reset pulse two clock cycles wide. If a hardware reset overrides the first cycle of a firmware set, the second cycle still sets the bit.
- R8: The true pin equals the stored bit when latch enable (control bit 0) and true-pin enable (bit 1) are both 1, and 0 otherwise. The inverted pin equals the complement of the stored bit when latch enable and inverted-pin enable (bit 2) are both 1, and 0 otherwise.
- R9: Reads of address 0 return the enable register. Reads of address 1 return control bits 2..0, with all other bits 0. A reset clears both registers, so both pins go to 0.
- R10: A reset does not change the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of registers, synchronizers and pulse generators |
| cmp1_i | input | 1 | Comparator 1 result, asynchronous |
| cmp2_i | input | 1 | Comparator 2 result, asynchronous |
| ext_pin_i | input | 1 | External event pin, asynchronous |
| clk_strobe_i | input | 1 | One-cycle strobe from the selectable clock, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 enables, 1 control |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| q_pin_o | output | 1 | Gated true output |
| qn_pin_o | output | 1 | Gated inverted output |

## Verification
Each result has a fixed latency, counted in rising edges from the cycle in which the bench drives the input:
- Comparator and pin events need three edges: two synchronizer stages, then the state flop.
- A strobe needs one edge.
- A firmware request needs two edges: the write edge loads the pulse generator, and the next edge updates the state.
- Register and pin-enable changes are visible right after the write edge.

The driver queues every expected value with the exact cycle number at which it falls due. The monitor compares only in that cycle, two nanoseconds after the edge. Some checks deliberately sample one cycle early to confirm that an event has not yet arrived.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int NSRC = 4;
  localparam int REG_W = 2 * NSRC;

  // hardware source slots inside the enable vectors
  localparam int SRC_CMP1 = 0;
  localparam int SRC_CMP2 = 1;
  localparam int SRC_PIN  = 2;
  localparam int SRC_STB  = 3;

  // control register fields
  localparam int CTL_LEN   = 0;
  localparam int CTL_QOE   = 1;
  localparam int CTL_QNOE  = 2;
  localparam int CTL_FWSET = 3;
  localparam int CTL_FWRST = 4;

  function automatic logic any_enabled(input logic [NSRC-1:0] src,
                                       input logic [NSRC-1:0] en);
    return |(src & en);
  endfunction

  // reset has priority over set
  function automatic logic latch_next(input logic cur, input logic set_i,
                                      input logic clr_i);
    if (clr_i) return 1'b0;
    if (set_i) return 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/srl_pulse.sv
module srl_pulse #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (trig_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/srl_regs.sv
module srl_regs
  import srl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_addr_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [NSRC-1:0]  set_en_o,
  output logic [NSRC-1:0]  clr_en_o,
  output logic             latch_en_o,
  output logic             q_oe_o,
  output logic             qn_oe_o,
  output logic             fw_set_trig_o,
  output logic             fw_clr_trig_o
);
  logic [REG_W-1:0] en_q;
  logic [2:0]       ctl_q;
  logic             wr_ctl;
  logic [REG_W-1:0] unused_ctl_bits;

  assign wr_ctl = wr_en_i && wr_addr_i;
  assign unused_ctl_bits = wr_data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      ctl_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i) ctl_q <= wr_data_i[CTL_QNOE:CTL_LEN];
      else           en_q  <= wr_data_i;
    end
  end

  // self-clearing request bits are never stored
  assign fw_set_trig_o = wr_ctl && wr_data_i[CTL_FWSET];
  assign fw_clr_trig_o = wr_ctl && wr_data_i[CTL_FWRST];

  assign set_en_o   = en_q[NSRC-1:0];
  assign clr_en_o   = en_q[REG_W-1:NSRC];
  assign latch_en_o = ctl_q[CTL_LEN];
  assign q_oe_o     = ctl_q[CTL_QOE];
  assign qn_oe_o    = ctl_q[CTL_QNOE];

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i) rd_data_o[2:0] = ctl_q;
    else           rd_data_o      = en_q;
  end
endmodule

// File: rtl/srl_latch_periph.sv
module srl_latch_periph
  import srl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PULSE_CYC   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp1_i,
  input  logic       cmp2_i,
  input  logic       ext_pin_i,
  input  logic       clk_strobe_i,
  input  logic       wr_en_i,
  input  logic       wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       q_pin_o,
  output logic       qn_pin_o
);
  localparam int NASYNC = 3;

  logic [NSRC-1:0]   set_en, clr_en, src_vec;
  logic [NASYNC-1:0] async_raw, async_sync;
  logic latch_en, q_oe, qn_oe;
  logic fw_set_trig, fw_clr_trig, fw_set_pulse, fw_clr_pulse;
  logic set_any, clr_any, state_q;

  srl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .set_en_o(set_en), .clr_en_o(clr_en),
    .latch_en_o(latch_en), .q_oe_o(q_oe), .qn_oe_o(qn_oe),
    .fw_set_trig_o(fw_set_trig), .fw_clr_trig_o(fw_clr_trig)
  );

  assign async_raw = {ext_pin_i, cmp2_i, cmp1_i};

  srl_sync #(.W(NASYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(async_raw), .q_o(async_sync)
  );

  always_comb begin
    src_vec           = '0;
    src_vec[SRC_CMP1] = async_sync[0];
    src_vec[SRC_CMP2] = async_sync[1];
    src_vec[SRC_PIN]  = async_sync[2];
    src_vec[SRC_STB]  = clk_strobe_i;
  end

  srl_pulse #(.CYC(PULSE_CYC)) u_fw_set (
    .clk(clk), .rst_n(rst_n), .trig_i(fw_set_trig), .pulse_o(fw_set_pulse)
  );
  srl_pulse #(.CYC(PULSE_CYC)) u_fw_clr (
    .clk(clk), .rst_n(rst_n), .trig_i(fw_clr_trig), .pulse_o(fw_clr_pulse)
  );

  assign set_any = any_enabled(src_vec, set_en) || fw_set_pulse;
  assign clr_any = any_enabled(src_vec, clr_en) || fw_clr_pulse;

  // deliberately no reset: the stored bit survives a device reset
  always_ff @(posedge clk) begin
    state_q <= latch_next(state_q, set_any, clr_any);
  end

  assign q_pin_o  = latch_en && q_oe  &&  state_q;
  assign qn_pin_o = latch_en && qn_oe && !state_q;
endmodule

// File: rtl/srl_latch_chk.sv
module srl_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       set_any,
  input logic       clr_any,
  input logic       state_q,
  input logic       fw_set_trig,
  input logic       fw_set_pulse,
  input logic       fw_clr_trig,
  input logic       fw_clr_pulse,
  input logic       rd_addr_i,
  input logic [7:0] rd_data_o,
  input logic       q_pin_o,
  input logic       qn_pin_o
);
  a_r1_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && !clr_any) |=> state_q);

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> !state_q);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_any && clr_any) |=> !state_q);

  a_r6_req_bits_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i |-> (rd_data_o[4:3] == 2'b00));

  a_r7_set_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
    fw_set_trig |=> fw_set_pulse ##1 fw_set_pulse);

  a_r7_clr_pulse_two: assert property (@(posedge clk) disable iff (!rst_n)
    fw_clr_trig |=> fw_clr_pulse ##1 fw_clr_pulse);

  a_r8_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_pin_o && qn_pin_o));
endmodule

bind srl_latch_periph srl_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_any(set_any), .clr_any(clr_any),
  .state_q(state_q), .fw_set_trig(fw_set_trig), .fw_set_pulse(fw_set_pulse),
  .fw_clr_trig(fw_clr_trig), .fw_clr_pulse(fw_clr_pulse),
  .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .q_pin_o(q_pin_o), .qn_pin_o(qn_pin_o)
);

// File: tb/srl_latch_periph_test.sv
module srl_latch_periph_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp1 = 1'b0, cmp2 = 1'b0, pin = 1'b0, strobe = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic q_pin, qn_pin;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    bit         is_rd;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srl_latch_periph uut (
    .clk(clk), .rst_n(rst_n), .cmp1_i(cmp1), .cmp2_i(cmp2),
    .ext_pin_i(pin), .clk_strobe_i(strobe),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .q_pin_o(q_pin), .qn_pin_o(qn_pin)
  );

  // monitor: compare every item that falls due this cycle
  always @(posedge clk) begin
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [7:0] act;
        act = sb[i].is_rd ? rd_data : {6'b0, qn_pin, q_pin};
        checks++;
        if (act !== sb[i].exp) begin
          errors++;
          $display("FAIL %s cycle %0d actual %02h expected %02h",
                   sb[i].tag, cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_pins(input int k, input logic q, input logic qn,
                          input string tag);
    item_t it;
    it.due = cyc + k; it.is_rd = 1'b0; it.exp = {6'b0, qn, q}; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic exp_rd(input int k, input logic [7:0] v, input string tag);
    item_t it;
    it.due = cyc + k; it.is_rd = 1'b1; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      summary();
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    // R9: reset state of registers and pins
    rd_addr = 1'b0; exp_rd(1, 8'h00, "R9 enables after reset"); tick(1);
    rd_addr = 1'b1; exp_rd(1, 8'h00, "R9 control after reset");
    exp_pins(1, 1'b0, 1'b0, "R9 pins after reset"); tick(1);

    wr(1'b1, 8'h07);
    exp_rd(1, 8'h07, "R9 control readback"); tick(1);

    // R6: firmware set, request bits read back as 0
    wr(1'b1, 8'h0F);
    exp_pins(1, 1'b1, 1'b0, "R6 firmware set");
    exp_rd(1, 8'h07, "R6 request bits read zero"); tick(3);
    wr(1'b1, 8'h17);
    exp_pins(1, 1'b0, 1'b1, "R6 firmware clear"); tick(3);

    // R1: comparator 1 set through synchronizer
    wr(1'b0, 8'h01);
    cmp1 = 1'b1;
    exp_pins(2, 1'b0, 1'b1, "R1 not yet after two edges");
    exp_pins(3, 1'b1, 1'b0, "R1 comparator 1 set"); tick(4);
    cmp1 = 1'b0; tick(2);

    // R2: pin clears
    wr(1'b0, 8'h40);
    pin = 1'b1;
    exp_pins(2, 1'b1, 1'b0, "R2 not yet after two edges");
    exp_pins(3, 1'b0, 1'b1, "R2 pin clear"); tick(4);
    pin = 1'b0; tick(2);

    // R4: comparator 2 and strobe not enabled for set
    cmp2 = 1'b1; strobe = 1'b1; tick(1); strobe = 1'b0;
    exp_pins(4, 1'b0, 1'b1, "R4 disabled sources ignored"); tick(5);
    cmp2 = 1'b0; tick(3);

    // R5: strobe set then strobe clear
    wr(1'b0, 8'h08);
    strobe = 1'b1; exp_pins(1, 1'b1, 1'b0, "R5 strobe set"); tick(1);
    strobe = 1'b0; tick(2);
    wr(1'b0, 8'h80);
    strobe = 1'b1; exp_pins(1, 1'b0, 1'b1, "R5 strobe clear"); tick(1);
    strobe = 1'b0;
    exp_pins(2, 1'b0, 1'b1, "R5 single event"); tick(3);

    // R3: same source enabled on both sides, clear wins
    wr(1'b0, 8'h22);
    rd_addr = 1'b0; exp_rd(1, 8'h22, "R9 enable readback"); tick(1);
    wr(1'b1, 8'h0F);
    exp_pins(1, 1'b1, 1'b0, "R6 firmware set before R3"); tick(2);
    cmp2 = 1'b1;
    exp_pins(3, 1'b0, 1'b1, "R3 clear dominates"); tick(4);
    cmp2 = 1'b0; tick(3);

    // R7: strobe clear overrides first pulse cycle, second cycle sets
    wr(1'b0, 8'h80);
    rd_addr = 1'b1;
    wr(1'b1, 8'h0F);
    strobe = 1'b1;
    exp_pins(1, 1'b0, 1'b1, "R7 clear wins first pulse cycle"); tick(1);
    strobe = 1'b0;
    exp_pins(1, 1'b1, 1'b0, "R7 second pulse cycle sets");
    exp_pins(2, 1'b1, 1'b0, "R7 state holds after pulse"); tick(3);

    // R8: output gating with stored bit 1
    wr(1'b1, 8'h05);
    exp_pins(1, 1'b0, 1'b0, "R8 true pin disabled"); tick(1);
    wr(1'b1, 8'h06);
    exp_pins(1, 1'b0, 1'b0, "R8 latch enable low"); tick(1);
    wr(1'b1, 8'h03);
    exp_pins(1, 1'b1, 1'b0, "R8 true pin only"); tick(1);

    // R10: reset keeps stored bit
    rst_n = 1'b0; tick(2); rst_n = 1'b1;
    exp_pins(1, 1'b0, 1'b0, "R9 pins off after reset");
    exp_rd(1, 8'h00, "R9 control cleared by reset"); tick(1);
    wr(1'b1, 8'h07);
    exp_pins(1, 1'b1, 1'b0, "R10 stored bit survives reset"); tick(3);

    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d items actual %0d expected 0",
               sb.size(), sb.size());
    end
    done = 1'b1;
    summary();
  end
endmodule